// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side sequencer for an 8-channel, 16-bit successive-approximation converter. The converter has a single line that both starts a conversion on its rising edge and frames the serial data exchange while it is low. For each accepted request the sequencer drops that line briefly and raises it again to start a conversion. It holds the line high for the programmed conversion time, then pulls it low and runs sixteen serial clocks. During those clocks it sends the 7-bit setup word and collects the 16-bit result. When it releases the line at the end of the exchange, the rising edge starts another conversion inside the converter. The sequencer waits that conversion out before it offers the result, so the next request can never land in the middle of a conversion.

The setup word sent during an exchange selects the input, polarity and power state for the conversion that its closing edge starts. The sequencer also keeps track of the converter's sleep state. If a word that clears the sleep bit follows one that set it, the sequencer refuses new requests for a programmed wake-up time. Conversion time, serial clock half-period and wake-up time are all given in system clock cycles.

Both user-side interfaces are valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle and outside the wake-up lockout, so a request made while busy waits with `req_valid` held and is never lost. The result is offered on `res_valid` and `res_data` and stays unchanged until the cycle where `res_ready` is high. A stalled consumer therefore keeps the sequencer busy and holds off further requests.

Top module: `adc_conv_seq`

## Requirements
- R1: Out of reset, `adc_cs_conv` is high, `adc_sck` and `adc_sdi` are low, `res_valid` and `busy` are low and `req_ready` is high.
- R2: A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low whenever `busy` is high. `busy` is high from the cycle after acceptance until the cycle after the result is taken.
- R3: After acceptance, `adc_cs_conv` goes low for exactly SCLK_HALF cycles and then high for exactly CONV_CYCLES cycles. It never falls while fewer than CONV_CYCLES high cycles have passed since its last rise.
- R4: While `adc_cs_conv` is high, `adc_sck` and `adc_sdi` are both held low.
- R5: The exchange has exactly 16 `adc_sck` periods. `adc_sck` starts low when `adc_cs_conv` falls, and each high and low phase lasts SCLK_HALF cycles.
- R6: `req_cfg` bit 6 selects single-ended (1) or differential (0), bit 5 is odd/sign, bits 4:3 are the input select, bit 2 is COM, bit 1 is unipolar (1) or bipolar (0), and bit 0 is sleep. The word goes out MSB first: bit 6 is on `adc_sdi` when `adc_cs_conv` falls, and each later bit follows an `adc_sck` falling edge. After the seventh bit `adc_sdi` stays low.
- R7: `adc_sdo` is sampled on each `adc_sck` rising edge, and the 16 samples form `res_data` with the first sample in bit 15.
- R8: After the exchange `adc_cs_conv` returns high, and `res_valid` rises only after exactly CONV_CYCLES further high cycles.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` does not change.
- R10: If an exchange sends sleep = 0 while the converter is asleep, `req_ready` stays low for WAKE_CYCLES cycles counted from the rise of `adc_cs_conv` that ends that exchange.
- R11: A word with sleep = 1, or a sleep = 0 word sent while awake, causes no lockout, and `req_ready` is high again right after the result is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_cfg | input | 7 | Setup word for the exchange (fields in R6) |
| busy | output | 1 | A request is in progress |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Captured conversion result |
| adc_cs_conv | output | 1 | Combined convert-start / frame line |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdi | output | 1 | Setup word to the converter |
| adc_sdo | input | 1 | Result data from the converter |

## Verification
The bench measures every phase length on the convert line: the short framing dip, the conversion hold and the wait after the exchange. A sequencer that starts the exchange early, or offers the result while the closing conversion is still running, shows up as a wrong count. A behavioural converter model drives results with patterns that isolate the MSB and the LSB, plus all-ones, all-zeros and alternating values, so a reversed or shifted capture gives a wrong word. The same model records the setup bits and flags any activity on the serial lines while the convert line is high. The sleep sequence checks both sides of the lockout: a lockout that is missing, too short or raised by the wrong word appears as a wrong `req_ready` or a wrong wake-up length. A stalled result consumer checks that the offered word neither drops nor changes.

// File: rtl/adc_conv_seq_pkg.sv
package adc_conv_seq_pkg;

  localparam int CFG_W = 7;
  localparam int RES_W = 16;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FRAME,
    SQ_CONV,
    SQ_XFER,
    SQ_TAIL,
    SQ_RESP
  } seq_state_e;

  typedef struct packed {
    logic       single_ended;
    logic       odd_sign;
    logic [1:0] in_sel;
    logic       com_ref;
    logic       unipolar;
    logic       sleep;
  } adc_setup_t;

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_serial_engine.sv
module adc_serial_engine #(
  parameter int CFG_W     = 7,
  parameter int RES_W     = 16,
  parameter int SCLK_HALF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             sdo_in,
  output logic             sck,
  output logic             sdi,
  output logic [RES_W-1:0] data,
  output logic             done
);

  localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BW = $clog2(RES_W + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(SCLK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(RES_W - 1);

  logic             active_q;
  logic [HW-1:0]    hcnt_q;
  logic [BW-1:0]    falls_q;
  logic [CFG_W-1:0] cfg_sh_q;
  logic [RES_W-1:0] cap_q;
  logic             sck_q;
  logic             sdi_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hcnt_q   <= '0;
      falls_q  <= '0;
      cfg_sh_q <= '0;
      cap_q    <= '0;
      sck_q    <= 1'b0;
      sdi_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        hcnt_q   <= '0;
        falls_q  <= '0;
        cfg_sh_q <= cfg_in;
        sck_q    <= 1'b0;
        sdi_q    <= cfg_in[CFG_W-1];
      end else if (active_q) begin
        if (hcnt_q == HALF_LAST) begin
          hcnt_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            cap_q <= {cap_q[RES_W-2:0], sdo_in};
          end else begin
            sck_q <= 1'b0;
            if (falls_q == BIT_LAST) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
              sdi_q    <= 1'b0;
            end else begin
              falls_q  <= falls_q + 1'b1;
              sdi_q    <= cfg_sh_q[CFG_W-2];
              cfg_sh_q <= {cfg_sh_q[CFG_W-2:0], 1'b0};
            end
          end
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end
    end
  end

  assign sck  = sck_q;
  assign sdi  = sdi_q;
  assign data = cap_q;
  assign done = done_q;

  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q);

endmodule

// File: rtl/adc_wake_guard.sv
module adc_wake_guard #(
  parameter int WAKE_CYCLES = 8000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic sleep_bit,
  output logic lock
);

  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic          asleep_q;
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      cnt_q    <= '0;
    end else if (frame_end && sleep_bit) begin
      asleep_q <= 1'b1;
      cnt_q    <= '0;
    end else if (frame_end && asleep_q) begin
      asleep_q <= 1'b0;
      cnt_q    <= WW'(WAKE_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign lock = (cnt_q != '0);

  // R10
  wake_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(asleep_q) && $past(frame_end));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 350,
  parameter int SCLK_HALF   = 3,
  parameter int WAKE_CYCLES = 8000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CFG_W-1:0] req_cfg,
  output logic             busy,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data,
  output logic             adc_cs_conv,
  output logic             adc_sck,
  output logic             adc_sdi,
  input  logic             adc_sdo
);

  localparam int TMAX = (CONV_CYCLES > SCLK_HALF) ? CONV_CYCLES : SCLK_HALF;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] FRAME_LOAD = TW'(SCLK_HALF - 1);
  localparam logic [TW-1:0] CONV_LOAD  = TW'(CONV_CYCLES - 1);

  seq_state_e state_q;
  adc_setup_t setup_q;
  logic       accept;
  logic       tmr_load;
  logic [TW-1:0] tmr_val;
  logic       tmr_exp;
  logic       eng_start;
  logic       eng_done;
  logic       wake_lock;

  assign accept    = req_valid && req_ready;
  assign req_ready = (state_q == SQ_IDLE) && !wake_lock;
  assign busy      = (state_q != SQ_IDLE);
  assign res_valid = (state_q == SQ_RESP);
  assign adc_cs_conv = !((state_q == SQ_FRAME) || (state_q == SQ_XFER));
  assign eng_start = (state_q == SQ_CONV) && tmr_exp;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CONV_LOAD;
    unique case (state_q)
      SQ_IDLE: begin
        tmr_load = accept;
        tmr_val  = FRAME_LOAD;
      end
      SQ_FRAME: tmr_load = tmr_exp;
      SQ_XFER:  tmr_load = eng_done;
      default:  tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      setup_q <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE:  if (accept) begin
                    state_q <= SQ_FRAME;
                    setup_q <= adc_setup_t'(req_cfg);
                  end
        SQ_FRAME: if (tmr_exp) state_q <= SQ_CONV;
        SQ_CONV:  if (tmr_exp) state_q <= SQ_XFER;
        SQ_XFER:  if (eng_done) state_q <= SQ_TAIL;
        SQ_TAIL:  if (tmr_exp) state_q <= SQ_RESP;
        SQ_RESP:  if (res_ready) state_q <= SQ_IDLE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  adc_phase_timer #(.W(TW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  adc_serial_engine #(
    .CFG_W     (CFG_W),
    .RES_W     (RES_W),
    .SCLK_HALF (SCLK_HALF)
  ) engine_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .cfg_in (setup_q),
    .sdo_in (adc_sdo),
    .sck    (adc_sck),
    .sdi    (adc_sdi),
    .data   (res_data),
    .done   (eng_done)
  );

  adc_wake_guard #(.WAKE_CYCLES(WAKE_CYCLES)) wake_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (eng_done),
    .sleep_bit (setup_q.sleep),
    .lock      (wake_lock)
  );

  // Checker state: consecutive high cycles of the convert line, saturating.
  localparam int CW = $clog2(CONV_CYCLES + 1);
  logic [CW-1:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= CW'(CONV_CYCLES);
    end else if (!adc_cs_conv) begin
      hi_run_q <= '0;
    end else if (hi_run_q != CW'(CONV_CYCLES)) begin
      hi_run_q <= hi_run_q + 1'b1;
    end
  end

  // R3
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_conv) |-> (hi_run_q == CW'(CONV_CYCLES)));

  // R4
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_conv |-> (!adc_sck && !adc_sdi));

  // R2
  busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R10
  wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_lock |-> !req_ready);

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

endmodule

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;

  localparam int CONV = 20;
  localparam int HALF = 2;
  localparam int WAKE = 300;
  localparam int NVEC = 6;

  // Each entry: {setup word [22:16], converter result [15:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {7'b1000000, 16'h8001},
    {7'b0111110, 16'hFFFF},
    {7'b1010100, 16'h0000},
    {7'b0101010, 16'hA55A},
    {7'b1111110, 16'h1234},
    {7'b0000010, 16'h7FFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_cfg = '0;
  logic        busy;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_data;
  logic        cs;
  logic        sck;
  logic        sdi;
  logic        sdo = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t_rise = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_conv_seq #(
    .CONV_CYCLES (CONV),
    .SCLK_HALF   (HALF),
    .WAKE_CYCLES (WAKE)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_cfg     (req_cfg),
    .busy        (busy),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_data    (res_data),
    .adc_cs_conv (cs),
    .adc_sck     (sck),
    .adc_sdi     (sdi),
    .adc_sdo     (adc_sdo_w)
  );

  logic adc_sdo_w;
  assign adc_sdo_w = sdo;

  // Behavioural converter: drives result bits, records setup bits.
  logic [15:0] m_word = '0;
  int  m_bidx = 0;
  int  m_rises = 0;
  int  m_half = 0;
  int  m_hi_run = 0;
  logic [6:0] m_cfg = '0;
  bit  m_late = 1'b0;
  bit  m_quiet_bad = 1'b0;
  logic p_cs = 1'b1;
  logic p_sck = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs && (sck || sdi)) m_quiet_bad = 1'b1;
      if (p_cs && !cs) begin
        m_bidx = 0; m_rises = 0; m_half = 0; m_hi_run = 0;
        m_cfg = '0; m_late = 1'b0;
        sdo = m_word[15];
      end
      if (!cs && !p_sck && sck) begin
        m_rises = m_rises + 1;
        if (m_rises <= 7) m_cfg = {m_cfg[5:0], sdi};
        else if (sdi) m_late = 1'b1;
      end
      if (!cs && sck) m_hi_run = m_hi_run + 1;
      if (!cs && p_sck && !sck) begin
        if (m_half == 0) m_half = m_hi_run;
        m_bidx = m_bidx + 1;
        if (m_bidx < 16) sdo = m_word[15 - m_bidx];
      end
      p_cs = cs;
      p_sck = sck;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [6:0] cfg, input logic [15:0] word, input int hold);
    int n;
    bit bad_busy;
    bit bad_bp;
    logic [15:0] d0;
    m_word = word;
    req_cfg = cfg;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    bad_busy = 1'b0;
    n = 0;
    while (!cs) begin
      n++;
      if (!busy || req_ready) bad_busy = 1'b1;
      @(negedge clk);
    end
    chk(n == HALF, "R3 framing dip length", n, HALF);
    n = 0;
    while (cs) begin
      n++;
      if (!busy || req_ready) bad_busy = 1'b1;
      @(negedge clk);
    end
    chk(n == CONV, "R3 conversion hold length", n, CONV);
    while (!cs) @(negedge clk);
    t_rise = cyc;
    n = 0;
    while (!res_valid) begin
      n++;
      if (!cs || !busy || req_ready) bad_busy = 1'b1;
      @(negedge clk);
    end
    chk(n == CONV, "R8 wait after exchange", n, CONV);
    chk(m_rises == 16, "R5 serial clock periods", m_rises, 16);
    chk(m_half == HALF, "R5 serial clock high phase", m_half, HALF);
    chk(m_cfg == cfg, "R6 setup word order", int'(m_cfg), int'(cfg));
    chk(!m_late, "R6 data line low after setup word", int'(m_late), 0);
    chk(res_data == word, "R7 captured result", int'(res_data), int'(word));
    chk(!bad_busy, "R2 busy high and ready low in progress", int'(bad_busy), 0);
    if (hold > 0) begin
      d0 = res_data;
      bad_bp = 1'b0;
      repeat (hold) begin
        @(negedge clk);
        if (!res_valid || res_data != d0) bad_bp = 1'b1;
      end
      chk(!bad_bp, "R9 result held under back-pressure", int'(bad_bp), 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!busy && !res_valid, "R2 busy clears after result taken",
        int'({busy, res_valid}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int diff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs && !sck && !sdi, "R1 serial lines at reset",
        int'({cs, sck, sdi}), 4);
    chk(!res_valid && !busy && req_ready, "R1 handshake at reset",
        int'({res_valid, busy, req_ready}), 1);
    repeat (5) @(negedge clk);
    chk(cs && !sck, "R1 no activity before first request", int'({cs, sck}), 2);

    for (int i = 0; i < NVEC; i++) begin
      run_txn(VEC[i][22:16], VEC[i][15:0], (i == 3) ? 6 : 0);
    end

    // Sleep word: no lockout of its own
    run_txn(7'b1000001, 16'h0F0F, 0);
    chk(req_ready == 1'b1, "R11 sleep word causes no lockout", int'(req_ready), 1);

    // Waking word: lockout counted from the closing edge
    run_txn(7'b1000000, 16'hC003, 0);
    chk(req_ready == 1'b0, "R10 ready low during wake-up", int'(req_ready), 0);
    chk(busy == 1'b0, "R10 idle while locked", int'(busy), 0);
    while (!req_ready) @(negedge clk);
    diff = cyc - t_rise;
    chk(diff >= WAKE - 1 && diff <= WAKE + 1, "R10 wake-up length", diff, WAKE);

    // Awake, sleep bit clear: no lockout
    run_txn(7'b0011000, 16'h5AA5, 3);
    chk(req_ready == 1'b1, "R11 awake word causes no lockout", int'(req_ready), 1);

    chk(!m_quiet_bad, "R4 serial lines quiet while convert line high",
        int'(m_quiet_bad), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule